// File: doc/BRIEF.md
# Limb-Serial Modular Adder/Subtractor

This block adds or subtracts two multi-limb integers modulo M. The integers travel through it as 17-bit limbs, least significant limb first. Both operands must already be reduced below M. The caller pulses `start` together with limb 0 of A, B and M and the operation select. It then presents the remaining limbs on the cycles that follow, one limb per cycle. Once the last limb is in, the reduced result streams out one limb per cycle, and `done` marks the final limb.

Internally the block runs two carry chains at once. The first chain forms A+B, or A−B for subtraction. The second chain takes each limb of that first result and subtracts M from it (addition) or adds M to it (subtraction). Both candidate results are held limb by limb. The carry out of the top limb then decides which candidate is correct, so no second pass over the data is needed. The operand width is NUM_LIMBS×17−2 bits, with NUM_LIMBS from 2 to 14. The default of 9 limbs gives 151-bit numbers.

Top module: `ma_modaddsub`

## Requirements
- R1: While reset is active, and on the first cycle after it, `out_valid` and `done` are 0.
- R2: An operation is accepted when `start` is high while the block is idle. The limbs of A, B and M at that cycle are limb 0. Limbs 1 to NUM_LIMBS−1 are taken on the following consecutive cycles. `sub_sel` is sampled only with limb 0, and 0 selects addition while 1 selects subtraction.
- R3: With `sub_sel`=0 the result is (A+B) mod M. A+B equal to M exactly gives 0, and A=B=0 gives 0.
- R4: With `sub_sel`=1 the result is (A−B) mod M. A=B gives 0, and A<B gives A−B+M.
- R5: `out_valid` is high for exactly NUM_LIMBS consecutive cycles. The run begins on the cycle after the last input limb is taken, and it carries the result limbs least significant first on `out_limb`.
- R6: `done` is high only together with the last result limb.
- R7: A `start` pulse that arrives while an operation is loading or emitting is ignored. It does not change the result, and it produces no additional output run.
- R8: Moduli that fill the whole operand width (up to 2^(NUM_LIMBS×17−2)−1) are handled correctly.
- R9: Every result is below M.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins an operation when idle; qualifies limb 0 |
| sub_sel | input | 1 | 0 = modular add, 1 = modular subtract; sampled with start |
| a_limb | input | LIMB_W | Current limb of operand A |
| b_limb | input | LIMB_W | Current limb of operand B |
| m_limb | input | LIMB_W | Current limb of modulus M |
| out_limb | output | LIMB_W | Current result limb |
| out_valid | output | 1 | `out_limb` carries a result limb |
| done | output | 1 | Last result limb is on `out_limb` |

## Verification
Several operand patterns are applied, each chosen to tell a different path apart.
- A sum equal to M exactly must take the reduced candidate, and a sum just under M must keep the plain one. Both cases are selected purely by the borrow out of the top limb.
- Zero operands, and equal operands in subtract mode, check that a result of zero never falls through to the M-corrected value.
- Subtraction with A<B checks that the wrap correctly adds M back.
- Random operands under random and full-width moduli exercise carry and borrow ripple across every limb boundary.
- One operation is hit by stray start pulses while it is loading and while it is emitting, which shows whether the sequencing can be disturbed.

// File: rtl/ma_pkg.sv
package ma_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOAD = 2'd1,
        PH_EMIT = 2'd2
    } phase_t;
endpackage

// File: rtl/ma_limb_adder.sv
// One limb of a ripple chain: x + (y or ~y) + cin.
module ma_limb_adder #(
    parameter int W = 17
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         invert_y,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W-1:0] y_eff;
    logic [W:0]   total;

    always_comb begin
        y_eff = invert_y ? ~y : y;
        total = {1'b0, x} + {1'b0, y_eff} + {{W{1'b0}}, cin};
        sum   = total[W-1:0];
        cout  = total[W];
    end
endmodule

// File: rtl/ma_limb_store.sv
// Shift buffer: writes enter at the tail; the head holds the oldest limb.
module ma_limb_store #(
    parameter int W     = 17,
    parameter int DEPTH = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift,
    input  logic [W-1:0] din,
    output logic [W-1:0] head
);
    logic [W-1:0] slot_q [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            if (i == DEPTH - 1) begin : g_tail
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)     slot_q[i] <= '0;
                    else if (shift) slot_q[i] <= din;
                end
            end else begin : g_body
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)     slot_q[i] <= '0;
                    else if (shift) slot_q[i] <= slot_q[i+1];
                end
            end
        end
    endgenerate

    assign head = slot_q[0];
endmodule

// File: rtl/ma_modaddsub.sv
module ma_modaddsub #(
    parameter int LIMB_W    = 17,
    parameter int NUM_LIMBS = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              sub_sel,
    input  logic [LIMB_W-1:0] a_limb,
    input  logic [LIMB_W-1:0] b_limb,
    input  logic [LIMB_W-1:0] m_limb,
    output logic [LIMB_W-1:0] out_limb,
    output logic              out_valid,
    output logic              done
);
    import ma_pkg::*;

    localparam int              CNT_W  = $clog2(NUM_LIMBS);
    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(NUM_LIMBS - 1);

    typedef struct packed {
        phase_t           phase;
        logic [CNT_W-1:0] cnt;
        logic             c1;       // carry of the A +/- B chain
        logic             c2;       // carry of the -/+ M chain
        logic             sub;
        logic             pick_sec;
    } state_t;

    state_t st_d, st_q;

    logic              idle_w, loading, op_sub, cin1, cin2, shift_w;
    logic [LIMB_W-1:0] p_sum, s_sum, p_din, s_din, p_head, s_head;
    logic              p_cout, s_cout;

    always_comb begin
        idle_w  = (st_q.phase == PH_IDLE);
        loading = (idle_w && start) || (st_q.phase == PH_LOAD);
        op_sub  = idle_w ? sub_sel  : st_q.sub;
        // subtraction: two's complement of B needs carry-in 1; M is added
        // addition: subtracting M needs carry-in 1 on the second chain
        cin1    = idle_w ? sub_sel  : st_q.c1;
        cin2    = idle_w ? ~sub_sel : st_q.c2;
    end

    ma_limb_adder #(.W(LIMB_W)) u_primary (
        .x(a_limb), .y(b_limb), .invert_y(op_sub), .cin(cin1),
        .sum(p_sum), .cout(p_cout)
    );

    ma_limb_adder #(.W(LIMB_W)) u_secondary (
        .x(p_sum), .y(m_limb), .invert_y(~op_sub), .cin(cin2),
        .sum(s_sum), .cout(s_cout)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.phase = PH_LOAD;
                    st_d.cnt   = CNT_W'(1);
                    st_d.c1    = p_cout;
                    st_d.c2    = s_cout;
                    st_d.sub   = sub_sel;
                end
            end
            PH_LOAD: begin
                st_d.c1 = p_cout;
                st_d.c2 = s_cout;
                if (st_q.cnt == LAST_C) begin
                    st_d.phase = PH_EMIT;
                    st_d.cnt   = '0;
                    // add: no borrow on A+B-M (carry 1) -> reduced value
                    // sub: borrow on A-B (carry 0) -> corrected value
                    st_d.pick_sec = st_q.sub ? ~p_cout : (p_cout | s_cout);
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end
            PH_EMIT: begin
                if (st_q.cnt == LAST_C) begin
                    st_d.phase = PH_IDLE;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase

        shift_w = loading || (st_q.phase == PH_EMIT);
        p_din   = loading ? p_sum : '0;
        s_din   = loading ? s_sum : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, cnt: '0, c1: 1'b0, c2: 1'b0,
                      sub: 1'b0, pick_sec: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    ma_limb_store #(.W(LIMB_W), .DEPTH(NUM_LIMBS)) u_store_pri (
        .clk(clk), .rst_n(rst_n), .shift(shift_w), .din(p_din), .head(p_head)
    );

    ma_limb_store #(.W(LIMB_W), .DEPTH(NUM_LIMBS)) u_store_sec (
        .clk(clk), .rst_n(rst_n), .shift(shift_w), .din(s_din), .head(s_head)
    );

    assign out_valid = (st_q.phase == PH_EMIT);
    assign done      = (st_q.phase == PH_EMIT) && (st_q.cnt == LAST_C);
    assign out_limb  = st_q.pick_sec ? s_head : p_head;
endmodule

// File: rtl/ma_modaddsub_chk.sv
module ma_modaddsub_chk #(
    parameter int NUM_LIMBS = 9
) (
    input logic clk,
    input logic rst_n,
    input logic out_valid,
    input logic done
);
    localparam int RUN_W = $clog2(NUM_LIMBS + 1) + 1;

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         run_q <= '0;
        else if (out_valid) run_q <= run_q + RUN_W'(1);
        else                run_q <= '0;
    end

    // R1: outputs quiet under reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !done));

    // R6: done only alongside a valid limb
    p_done_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> out_valid);

    // R5: done arrives after exactly NUM_LIMBS-1 earlier valid cycles
    p_run_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_q == RUN_W'(NUM_LIMBS - 1)));

    // R5: the run is unbroken until done
    p_run_cont_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !done) |=> out_valid);

    // R7: no further limb follows the last one
    p_no_tail_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !out_valid);
endmodule

bind ma_modaddsub ma_modaddsub_chk #(.NUM_LIMBS(NUM_LIMBS)) u_chk (
    .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .done(done)
);

// File: tb/ma_modaddsub_tb.sv
module ma_modaddsub_tb;
    localparam int W   = 17;
    localparam int NL  = 9;
    localparam int TOT = W * NL;
    localparam int OPW = TOT - 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         sub_sel = 1'b0;
    logic [W-1:0] a_limb = '0, b_limb = '0, m_limb = '0;
    logic [W-1:0] out_limb;
    logic         out_valid, done;

    int n_checks = 0;
    int n_fail   = 0;

    logic [TOT-1:0] exp_q[$];
    logic [TOT-1:0] mod_q[$];
    string          tag_q[$];

    always #10 clk = ~clk;

    ma_modaddsub #(.LIMB_W(W), .NUM_LIMBS(NL)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .sub_sel(sub_sel),
        .a_limb(a_limb), .b_limb(b_limb), .m_limb(m_limb),
        .out_limb(out_limb), .out_valid(out_valid), .done(done)
    );

    function automatic logic [TOT-1:0] rnd_wide();
        logic [TOT-1:0] v = '0;
        for (int k = 0; k < 5; k++) v = (v << 32) | TOT'($urandom);
        return v & ((TOT'(1) << OPW) - 1);
    endfunction

    function automatic logic [TOT-1:0] ref_result(logic [TOT-1:0] a,
            logic [TOT-1:0] b, logic [TOT-1:0] m, logic sub);
        logic [TOT-1:0] s;
        if (!sub) begin
            s = a + b;
            if (s >= m) s = s - m;
        end else begin
            s = (a >= b) ? a - b : a + m - b;
        end
        return s;
    endfunction

    // driver: pushes expectation, then feeds limbs; optional stray starts
    task automatic run_op(logic [TOT-1:0] a, logic [TOT-1:0] b,
            logic [TOT-1:0] m, logic sub, string tag, bit stray);
        exp_q.push_back(ref_result(a, b, m, sub));
        mod_q.push_back(m);
        tag_q.push_back(tag);
        for (int j = 0; j < NL; j++) begin
            @(negedge clk);
            start   = (j == 0) || (stray && j == 3);
            sub_sel = (j == 0) ? sub : ~sub;
            a_limb  = a[j*W +: W];
            b_limb  = b[j*W +: W];
            m_limb  = m[j*W +: W];
        end
        for (int k = 0; k < NL; k++) begin
            @(negedge clk);
            start   = stray && (k == 0);
            sub_sel = ~sub;
            a_limb  = W'($urandom);
            b_limb  = W'($urandom);
            m_limb  = W'($urandom);
        end
        start = 1'b0;
    endtask

    // monitor: collects limbs, compares on done
    int             idx = 0;
    logic [TOT-1:0] acc = '0;
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (idx == 0 && exp_q.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL R7: output run with no operation pending (actual limb %0h, expected none)", out_limb);
            end
            acc[idx*W +: W] = out_limb;
            if (done) begin
                logic [TOT-1:0] e, m;
                string t;
                n_checks++;
                if (idx != NL - 1) begin
                    n_fail++;
                    $display("FAIL R6: done at limb %0d, expected %0d", idx, NL - 1);
                end
                if (exp_q.size() > 0) begin
                    e = exp_q.pop_front(); m = mod_q.pop_front(); t = tag_q.pop_front();
                    n_checks++;
                    if (acc !== e) begin
                        n_fail++;
                        $display("FAIL %s: result %0h, expected %0h", t, acc, e);
                    end
                    n_checks++;
                    if (acc >= m) begin
                        n_fail++;
                        $display("FAIL R9: result %0h not below modulus %0h", acc, m);
                    end
                end
                idx = 0;
                acc = '0;
            end else begin
                idx++;
            end
        end
    end

    bit finished = 0;
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: run did not complete (actual hung, expected finish)");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [TOT-1:0] m, a, b, mmax;
        repeat (3) @(negedge clk);
        n_checks++;  // R1
        if (out_valid !== 1'b0 || done !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: valid=%b done=%b in reset, expected 0 0", out_valid, done);
        end
        rst_n = 1'b1;
        @(negedge clk);
        n_checks++;  // R1 after release
        if (out_valid !== 1'b0 || done !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: valid=%b done=%b after reset, expected 0 0", out_valid, done);
        end

        mmax = (TOT'(1) << OPW) - 1;
        m = rnd_wide() | 1;
        a = m / 3;
        run_op(a, m - a, m, 1'b0, "R3 sum equals M", 0);
        run_op(a, m - a - 1, m, 1'b0, "R3 sum just under M", 0);
        run_op('0, '0, m, 1'b0, "R3 zero add", 0);
        run_op('0, '0, m, 1'b1, "R4 zero sub", 0);
        run_op(a, a, m, 1'b1, "R4 equal sub", 0);
        run_op(a, a + 5, m, 1'b1, "R4 A below B", 0);
        run_op(mmax - 1, mmax - 1, mmax, 1'b0, "R8 full-width add", 0);
        run_op(TOT'(1), mmax - 1, mmax, 1'b1, "R8 full-width sub", 0);
        run_op(mmax - 1, TOT'(1), mmax, 1'b0, "R8 full-width wrap add", 0);
        run_op(m - 1, m - 2, m, 1'b1, "R7 stray starts", 1);
        for (int i = 0; i < 40; i++) begin
            m = rnd_wide() | 1;
            a = rnd_wide() % m;
            b = rnd_wide() % m;
            run_op(a, b, m, i[0], i[0] ? "R4 random sub" : "R3 random add", 0);
        end
        for (int i = 0; i < 6; i++) begin
            a = rnd_wide() % mmax;
            b = rnd_wide() % mmax;
            run_op(a, b, mmax, i[0], "R8 random full-width", 0);
        end
        repeat (3 * NL) @(negedge clk);
        n_checks++;  // R2/R7: every accepted operation produced exactly one run
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R2: %0d results missing, expected 0", exp_q.size());
        end
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule